// File: doc/BRIEF.md
# Residue-Checked Adder/Subtractor

This block adds or subtracts two data words. Each word travels with a separate check field that holds its residue modulo a low-cost odd modulus A = 2^a - 1. The main datapath is a ripple-carry adder that forms the result. A separate check path predicts the result residue using only the operand check fields. A checker then recomputes the residue of the result the adder actually produced, including the carry out of the top bit, and compares it with the prediction. If the two differ, the block raises an error flag.

A fault on a single carry can invert a long run of result bits, yet it changes the numeric value by only plus or minus one power of two. Such an error is never zero modulo an odd A, so it is always caught. The block has one register stage. Result, result check field and error flag appear one cycle after the input strobe. A test-only input flips individual carries inside the adder so that the detection path can be exercised.

Defaults are a 16-bit word and a = 4 (A = 15). Residues are formed by summing 4-bit slices with end-around carry. Because 2^16 leaves residue 1 modulo 15, the carry out of bit 15 adds exactly 1 to the recomputed residue.

Top module: `rescheck_addsub`

## Requirements
- R1: With `op_sub` = 0, `out_data` equals (`a_data` + `b_data`) mod 2^16, captured from the cycle in which `in_vld` is high.
- R2: With `op_sub` = 1, `out_data` equals (`a_data` - `b_data`) mod 2^16. A borrow wraps the result around.
- R3: `out_vld` is high exactly one cycle after a cycle with `in_vld` high. While `in_vld` is low, `out_data` and `out_chk` keep their previous values.
- R4: `out_chk` equals `out_data` mod 15, in the range 0 to 14.
- R5: When `flt_inj` is zero and both operand check fields match their data modulo 15, `out_err` stays low for every operand pair and both operations, including results that wrap.
- R6: When `flt_inj` has exactly one bit i set, the carry entering sum bit i is inverted (bit 0 is the carry-in), and `out_err` is high in the output cycle.
- R7: When an operand check field differs from its data's residue by a nonzero amount modulo 15, `out_err` is high in the output cycle.
- R8: `out_err` is low whenever `out_vld` is low, and is low after reset.
- R9: An operand check field of 15 stands for residue zero and raises no error when its data is a multiple of 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract b from a |
| a_data | input | DW | First operand data |
| a_chk | input | RA | First operand residue mod 2^RA-1 |
| b_data | input | DW | Second operand data |
| b_chk | input | RA | Second operand residue mod 2^RA-1 |
| flt_inj | input | DW | Test only: bit i inverts the carry into sum bit i |
| out_vld | output | 1 | Result valid |
| out_data | output | DW | Result data mod 2^DW |
| out_chk | output | RA | Residue of out_data |
| out_err | output | 1 | Predicted and recomputed residues disagree |

## Verification
Two functions can fall in the same cycle: the fold of the adder's carry out into the recomputed residue, and a carry fault injected into the same addition. The bench provokes both together by sweeping single carry flips over every bit position, for both operations. It uses operand pairs that wrap, such as all-ones plus one and zero minus one, as well as random pairs. In every such case the flag must rise. The same wrapping pairs with no injection must leave the flag low and must give a wrapped result whose check field is correct.

// File: rtl/rescheck_addsub.sv
module rescheck_addsub #(
  parameter int DW = 16,
  parameter int RA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          op_sub,
  input  logic [DW-1:0] a_data,
  input  logic [RA-1:0] a_chk,
  input  logic [DW-1:0] b_data,
  input  logic [RA-1:0] b_chk,
  input  logic [DW-1:0] flt_inj,
  output logic          out_vld,
  output logic [DW-1:0] out_data,
  output logic [RA-1:0] out_chk,
  output logic          out_err
);

  localparam int NSL = (DW + RA - 1) / RA;
  localparam int PW  = NSL * RA;
  localparam logic [RA-1:0] RMAX = '1;
  localparam logic [RA-1:0] CW   = RA'(1) << (DW % RA);

  function automatic logic [RA-1:0] fold_add(input logic [RA-1:0] p, input logic [RA-1:0] q);
    logic [RA:0] s;
    s = {1'b0, p} + {1'b0, q};
    return s[RA-1:0] + {{(RA-1){1'b0}}, s[RA]};
  endfunction

  function automatic logic [RA-1:0] canon(input logic [RA-1:0] r);
    return (r == RMAX) ? '0 : r;
  endfunction

  function automatic logic [RA-1:0] resid(input logic [DW-1:0] v);
    logic [PW-1:0] pv;
    logic [RA-1:0] acc;
    pv = '0;
    pv[DW-1:0] = v;
    acc = '0;
    for (int k = 0; k < NSL; k++) acc = fold_add(acc, pv[k*RA +: RA]);
    return canon(acc);
  endfunction

  logic [DW-1:0] yop, sum;
  logic          cout, cc, ce;

  assign yop = op_sub ? ~b_data : b_data;

  always_comb begin
    cc  = op_sub;
    ce  = 1'b0;
    sum = '0;
    for (int i = 0; i < DW; i++) begin
      ce     = cc ^ flt_inj[i];
      sum[i] = a_data[i] ^ yop[i] ^ ce;
      cc     = (a_data[i] & yop[i]) | (ce & (a_data[i] ^ yop[i]));
    end
    cout = cc;
  end

  logic [RA-1:0] pred, act_raw, act, sum_res;
  logic          mismatch;

  assign pred     = canon(fold_add(canon(a_chk), op_sub ? ~canon(b_chk) : canon(b_chk)));
  assign sum_res  = resid(sum);
  assign act_raw  = fold_add(sum_res, cout ? CW : '0);
  assign act      = canon(op_sub ? fold_add(act_raw, ~CW) : act_raw);
  assign mismatch = (pred != act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_err  <= 1'b0;
      out_data <= '0;
      out_chk  <= '0;
    end else begin
      out_vld <= in_vld;
      out_err <= in_vld & mismatch;
      if (in_vld) begin
        out_data <= sum;
        out_chk  <= sum_res;
      end
    end
  end

  a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_data) && $stable(out_chk)));
  a_r4_chk_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_chk != RMAX));
  a_r5_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && flt_inj == '0 && canon(a_chk) == resid(a_data) && canon(b_chk) == resid(b_data))
      |=> !out_err);
  a_r6_flip_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && $countones(flt_inj) == 1 && canon(a_chk) == resid(a_data)
      && canon(b_chk) == resid(b_data)) |=> out_err);
  a_r8_err_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_vld);

endmodule

// File: tb/tb_rescheck_addsub.sv
module tb_rescheck_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0, op_sub = 1'b0;
  logic [15:0] a_data = '0, b_data = '0, flt_inj = '0;
  logic [3:0]  a_chk = '0, b_chk = '0;
  logic        out_vld, out_err;
  logic [15:0] out_data;
  logic [3:0]  out_chk;
  int ntest = 0, nfail = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  rescheck_addsub dut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sub(op_sub),
    .a_data(a_data), .a_chk(a_chk), .b_data(b_data), .b_chk(b_chk), .flt_inj(flt_inj),
    .out_vld(out_vld), .out_data(out_data), .out_chk(out_chk), .out_err(out_err));

  function automatic logic [3:0] m15(input logic [15:0] v);
    return 4'(v % 16'd15);
  endfunction

  function automatic logic [15:0] ref_res(input logic [15:0] a, b, input logic s);
    return s ? 16'(a - b) : 16'(a + b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, b, input logic s,
                       input logic [3:0] ac, bc, input logic [15:0] inj);
    @(negedge clk);
    a_data = a; b_data = b; op_sub = s; a_chk = ac; b_chk = bc; flt_inj = inj; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; flt_inj = '0;
  endtask

  task automatic clean_op(input string req, input logic [15:0] a, b, input logic s);
    logic [15:0] e;
    e = ref_res(a, b, s);
    apply(a, b, s, m15(a), m15(b), '0);
    check({req, " data"}, 32'(out_data), 32'(e));
    check("R4 chk", 32'(out_chk), 32'(m15(e)));
    check("R5 no err", 32'(out_err), 0);
    check("R3 vld", 32'(out_vld), 1);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R8 reset err", 32'(out_err), 0);
    check("R3 reset vld", 32'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    clean_op("R1 wrap", 16'hFFFF, 16'h0001, 1'b0);
    clean_op("R1 max", 16'hFFFF, 16'hFFFF, 1'b0);
    clean_op("R2 borrow", 16'h0000, 16'h0001, 1'b1);
    clean_op("R2 equal", 16'h1234, 16'h1234, 1'b1);
    clean_op("R1 zero", 16'h0000, 16'h0000, 1'b0);

    // R3: idle cycles hold the last result and drop valid
    begin
      logic [15:0] held;
      held = out_data;
      repeat (3) @(negedge clk);
      check("R3 hold", 32'(out_data), 32'(held));
      check("R3 idle vld", 32'(out_vld), 0);
      check("R8 idle err", 32'(out_err), 0);
    end

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a, b;
      logic s;
      a = 16'($urandom); b = 16'($urandom); s = 1'($urandom);
      clean_op(s ? "R2 rand" : "R1 rand", a, b, s);
    end

    // R6: one flipped carry per position, with wrapping and random operands
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 16; i++) begin
        logic [15:0] a, b;
        a = (s == 0) ? 16'hFFFF : 16'h0000;
        b = 16'h0001;
        apply(a, b, 1'(s), m15(a), m15(b), 16'(1) << i);
        check("R6 flip wrap", 32'(out_err), 1);
        a = 16'($urandom); b = 16'($urandom);
        apply(a, b, 1'(s), m15(a), m15(b), 16'(1) << i);
        check("R6 flip rand", 32'(out_err), 1);
      end
    end

    // R7: corrupted operand check fields
    for (int k = 1; k < 15; k++) begin
      logic [15:0] a, b;
      a = 16'($urandom); b = 16'($urandom);
      apply(a, b, 1'(k & 1), 4'((m15(a) + k) % 15), m15(b), '0);
      check("R7 bad a_chk", 32'(out_err), 1);
      apply(a, b, 1'(~k & 1), m15(a), 4'((m15(b) + k) % 15), '0);
      check("R7 bad b_chk", 32'(out_err), 1);
    end

    // R9: a check field of 15 stands for zero
    apply(16'd0, 16'd30, 1'b0, 4'd15, 4'd15, '0);
    check("R9 fifteen add", 32'(out_err), 0);
    check("R9 data", 32'(out_data), 30);
    apply(16'd45, 16'd15, 1'b1, 4'd15, 4'd0, '0);
    check("R9 fifteen sub", 32'(out_err), 0);
    check("R9 chk", 32'(out_chk), 0);

    @(negedge clk);
    check("R8 err after idle", 32'(out_err), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ntest++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule